// File: doc/BRIEF.md
# Two-Wire Control and Status Slave for a TV Audio Decoder

This block lets a host processor configure a television audio decoder and read back its pilot and second-program detectors over a standard I2C bus. A fast system clock samples SCL and SDA. Both lines are synchronised and glitch-filtered, then reduced to bus events: START, STOP, and rising and falling clock edges. The slave answers one fixed 7-bit address. It pulls SDA low to acknowledge and never stretches the clock.

A write transfer carries up to two meaningful bytes. The first is the main control byte, which sets the audio mode, forced mono, mute, level control, second-program output level and input source. The second selects an internal monitor point for test. A STOP that comes straight after the main byte returns the monitor select to normal operation. A read transfer returns one status byte. Its two upper bits are snapshots of the stereo and second-program detector inputs.

Top module: `tv_audio_ctl_slave`

## Requirements
- R1: After reset every control output is 0 and the slave does not pull SDA.
- R2: The slave acknowledges an address byte whose upper seven bits are 1000000 (bit 0 is R/W: 0 write, 1 read) by holding SDA low through the ninth clock. Any other address gets no acknowledge, and the slave then ignores the bus, including later data bytes, until the next START or STOP.
- R3: Bytes arrive MSB first. The first data byte of a write loads the main control byte: bits 1:0 drive `audio_mode_o` (0 and 3 automatic, 1 second program, 2 both), bit 2 forced mono, bit 3 mute, bit 4 level-control enable, bit 5 selects the higher second-program output level, bit 6 selects baseband input. Bit 7 drives no output.
- R4: The second data byte of a write loads the monitor select. `test_sel_o` shows the byte value for values 0 to 13 and shows 0 for 14 and above.
- R5: A STOP ending a write in which exactly one data byte was completed clears the monitor select to 0.
- R6: A data byte interrupted by a STOP or a repeated START before its eighth bit changes no register.
- R7: A read returns the byte {stereo flag, second-program flag, 000000}, MSB first. The byte is captured when the read address is acknowledged and does not change while it is shifted out. Further bytes of the same read repeat the captured value.
- R8: During a read the slave releases SDA for the ninth clock of each byte. A master NACK ends the read, and SDA stays released.
- R9: Data bytes after the second byte of a write are acknowledged and change no output.
- R10: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| stereo_det_i | input | 1 | Stereo pilot detector flag |
| sap_det_i | input | 1 | Second-program carrier detector flag |
| audio_mode_o | output | 2 | Audio mode field |
| force_mono_o | output | 1 | Forced mono |
| mute_o | output | 1 | Mute |
| alc_en_o | output | 1 | Automatic level control enable (0 bypass) |
| sap_level_o | output | 1 | Second-program output level select |
| baseband_o | output | 1 | 1 baseband input, 0 sound-IF input |
| test_sel_o | output | TEST_W | Monitor point select code |

## Verification
Writes of one, two and three data bytes are mixed with random payloads. This shows apart the main-byte load, the monitor-byte load, the clear on an early STOP and the discard of surplus bytes. Partial bytes ended by a STOP or by a repeated START, mismatched addresses and monitor codes on both sides of 13/14 cover the discard and limit rules. Reads with detector inputs that flip in the middle of a byte separate capture-at-acknowledge from live sampling. Writes with one- and two-cycle spikes on both lines show whether the filter lets a false clock edge or a false START through.

// File: rtl/tacs_pkg.sv
package tacs_pkg;

   localparam int BYTE_W    = 8;
   localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      LS_IDLE,
      LS_ADDR,
      LS_WDATA,
      LS_RDATA,
      LS_IGNORE
   } link_state_e;

   typedef struct packed {
      logic       baseband;
      logic       sap_level;
      logic       alc_en;
      logic       mute;
      logic       force_mono;
      logic [1:0] mode;
   } ctrl_t;

   function automatic logic [BYTE_W-1:0] status_byte(input logic stereo, input logic sap);
      return {stereo, sap, {(BYTE_W-2){1'b0}}};
   endfunction

endpackage

// File: rtl/tacs_deglitch.sv
module tacs_deglitch #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_CYCLES = 4,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   localparam int CNT_W = $clog2(FILT_CYCLES + 1);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("FILT_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;
   logic [CNT_W-1:0]       run_q;

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
         else        sync_q <= raw_i;
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clean_o <= IDLE_LEVEL;
         run_q   <= '0;
      end else if (sync_out == clean_o) begin
         run_q <= '0;
      end else if (run_q == CNT_W'(FILT_CYCLES - 1)) begin
         clean_o <= sync_out;
         run_q   <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   if (FILT_CYCLES > 1) begin : g_chk
      // a level that has only just started to differ must not pass yet
      assert_fresh_change_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ((sync_out != clean_o) && $past(sync_out == clean_o)) |=> $stable(clean_o));
   end

endmodule

// File: rtl/tacs_edges.sv
module tacs_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic ev_start,
   output logic ev_stop,
   output logic ev_rise,
   output logic ev_fall
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end

   assign ev_rise  =  scl_f & ~scl_p;
   assign ev_fall  = ~scl_f &  scl_p;
   assign ev_start =  scl_f &  scl_p &  sda_p & ~sda_f;
   assign ev_stop  =  scl_f &  scl_p & ~sda_p &  sda_f;

endmodule

// File: rtl/tacs_link.sv
module tacs_link
   import tacs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_rise,
   input  logic              ev_fall,
   input  logic              sda_f,
   input  logic              stereo_det,
   input  logic              sap_det,
   output logic              wr_main,
   output logic              wr_test,
   output logic              clr_test,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_low
);
   link_state_e          st_q;
   logic [BIT_CNT_W-1:0] bit_q;
   logic                 ack_q;
   logic [BYTE_W-1:0]    sh_q;
   logic [BYTE_W-1:0]    stat_q;
   logic [1:0]           nwr_q;
   logic [2:0]           out_idx;
   logic                 in_xfer;

   assign out_idx = 3'(4'd7 - 4'(bit_q));
   assign in_xfer = (st_q == LS_ADDR) || (st_q == LS_WDATA) || (st_q == LS_RDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= LS_IDLE;
         bit_q    <= '0;
         ack_q    <= 1'b0;
         sh_q     <= '0;
         stat_q   <= '0;
         nwr_q    <= '0;
         wr_main  <= 1'b0;
         wr_test  <= 1'b0;
         clr_test <= 1'b0;
         wr_data  <= '0;
         sda_low  <= 1'b0;
      end else begin
         wr_main  <= 1'b0;
         wr_test  <= 1'b0;
         clr_test <= 1'b0;
         if (ev_start) begin
            st_q    <= LS_ADDR;
            bit_q   <= '0;
            ack_q   <= 1'b0;
            nwr_q   <= '0;
            sda_low <= 1'b0;
         end else if (ev_stop) begin
            if (st_q == LS_WDATA && nwr_q == 2'd1) clr_test <= 1'b1;
            st_q    <= LS_IDLE;
            bit_q   <= '0;
            ack_q   <= 1'b0;
            sda_low <= 1'b0;
         end else if (in_xfer && ev_rise) begin
            if (ack_q) begin
               if (st_q == LS_RDATA && sda_f) st_q <= LS_IGNORE;   // master NACK
            end else if (bit_q < BIT_CNT_W'(BYTE_W)) begin
               sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
               bit_q <= bit_q + 1'b1;
               if (bit_q == BIT_CNT_W'(BYTE_W - 1) && st_q == LS_WDATA) begin
                  wr_data <= {sh_q[BYTE_W-2:0], sda_f};
                  wr_main <= (nwr_q == 2'd0);
                  wr_test <= (nwr_q == 2'd1);
                  if (nwr_q != 2'd2) nwr_q <= nwr_q + 1'b1;
               end
            end
         end else if (in_xfer && ev_fall) begin
            if (ack_q) begin
               ack_q   <= 1'b0;
               bit_q   <= '0;
               sda_low <= 1'b0;
               if (st_q == LS_ADDR) st_q <= sh_q[0] ? LS_RDATA : LS_WDATA;
               if ((st_q == LS_ADDR && sh_q[0]) || st_q == LS_RDATA) sda_low <= ~stat_q[BYTE_W-1];
            end else if (bit_q == BIT_CNT_W'(BYTE_W)) begin
               ack_q <= 1'b1;
               if (st_q == LS_ADDR) begin
                  if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                     sda_low <= 1'b1;
                     if (sh_q[0]) stat_q <= status_byte(stereo_det, sap_det);
                  end else begin
                     st_q    <= LS_IGNORE;
                     sda_low <= 1'b0;
                  end
               end else begin
                  sda_low <= (st_q == LS_WDATA);
               end
            end else if (st_q == LS_RDATA) begin
               sda_low <= ~stat_q[out_idx];
            end
         end
      end
   end

   assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_IGNORE) |-> !sda_low);

   assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_RDATA && $past(st_q) == LS_RDATA) |-> $stable(stat_q));

   assert_start_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> !sda_low);

   assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_main && wr_test));

endmodule

// File: rtl/tacs_ctrl_regs.sv
module tacs_ctrl_regs
   import tacs_pkg::*;
#(
   parameter int TEST_W    = 4,
   parameter int TEST_LIVE = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_main,
   input  logic              wr_test,
   input  logic              clr_test,
   input  logic [BYTE_W-1:0] wr_data,
   output ctrl_t             ctrl_o,
   output logic [TEST_W-1:0] test_sel_o
);
   if (TEST_LIVE > (1 << TEST_W)) begin : g_bad_live
      $error("TEST_LIVE exceeds the range of TEST_W");
   end

   ctrl_t             ctrl_q;
   logic [BYTE_W-1:0] test_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         test_q <= '0;
      end else begin
         if (wr_main)       ctrl_q <= ctrl_t'(wr_data[BYTE_W-2:0]);
         if (clr_test)      test_q <= '0;
         else if (wr_test)  test_q <= wr_data;
      end
   end

   assign ctrl_o     = ctrl_q;
   assign test_sel_o = (test_q < BYTE_W'(TEST_LIVE)) ? test_q[TEST_W-1:0] : '0;

   assert_clear_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_test |=> (test_sel_o == '0));

   assert_main_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_main |=> $stable(ctrl_o));

endmodule

// File: rtl/tv_audio_ctl_slave.sv
module tv_audio_ctl_slave
   import tacs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1000000,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_CYCLES = 4,
   parameter int         TEST_W      = 4,
   parameter int         TEST_LIVE   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic              stereo_det_i,
   input  logic              sap_det_i,
   output logic [1:0]        audio_mode_o,
   output logic              force_mono_o,
   output logic              mute_o,
   output logic              alc_en_o,
   output logic              sap_level_o,
   output logic              baseband_o,
   output logic [TEST_W-1:0] test_sel_o
);
   localparam int N_LINES = 2;   // index 1 = SCL, 0 = SDA

   logic [N_LINES-1:0] raw_lines, clean_lines;
   logic ev_start, ev_stop, ev_rise, ev_fall;
   logic wr_main, wr_test, clr_test;
   logic [BYTE_W-1:0] wr_data;
   ctrl_t ctrl;

   assign raw_lines = {scl_i, sda_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      tacs_deglitch #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_CYCLES(FILT_CYCLES),
         .IDLE_LEVEL (1'b1)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw_lines[g]),
         .clean_o(clean_lines[g])
      );
   end

   tacs_edges u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (clean_lines[1]),
      .sda_f   (clean_lines[0]),
      .ev_start(ev_start),
      .ev_stop (ev_stop),
      .ev_rise (ev_rise),
      .ev_fall (ev_fall)
   );

   tacs_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_start  (ev_start),
      .ev_stop   (ev_stop),
      .ev_rise   (ev_rise),
      .ev_fall   (ev_fall),
      .sda_f     (clean_lines[0]),
      .stereo_det(stereo_det_i),
      .sap_det   (sap_det_i),
      .wr_main   (wr_main),
      .wr_test   (wr_test),
      .clr_test  (clr_test),
      .wr_data   (wr_data),
      .sda_low   (sda_pull_o)
   );

   tacs_ctrl_regs #(.TEST_W(TEST_W), .TEST_LIVE(TEST_LIVE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_main   (wr_main),
      .wr_test   (wr_test),
      .clr_test  (clr_test),
      .wr_data   (wr_data),
      .ctrl_o    (ctrl),
      .test_sel_o(test_sel_o)
   );

   assign audio_mode_o = ctrl.mode;
   assign force_mono_o = ctrl.force_mono;
   assign mute_o       = ctrl.mute;
   assign alc_en_o     = ctrl.alc_en;
   assign sap_level_o  = ctrl.sap_level;
   assign baseband_o   = ctrl.baseband;

endmodule

// File: tb/tv_audio_ctl_slave_test.sv
module tv_audio_ctl_slave_test;
   localparam int         Q    = 25;
   localparam logic [6:0] ADDR = 7'b1000000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic stereo = 1'b0, sap = 1'b0;
   logic glitch_en = 1'b0;
   logic sda_pull, sda_bus;
   logic [1:0] audio_mode;
   logic force_mono, mute, alc_en, sap_level, baseband;
   logic [3:0] test_sel;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [7:0] exp_main = 8'h00, exp_test = 8'h00;

   assign sda_bus = sda_m & ~sda_pull;
   always #5 clk = ~clk;

   tv_audio_ctl_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull_o(sda_pull),
      .stereo_det_i(stereo), .sap_det_i(sap), .audio_mode_o(audio_mode),
      .force_mono_o(force_mono), .mute_o(mute), .alc_en_o(alc_en),
      .sap_level_o(sap_level), .baseband_o(baseband), .test_sel_o(test_sel)
   );

   function automatic logic [3:0] exp_code(input logic [7:0] b);
      return (b < 8'd14) ? b[3:0] : 4'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_xfer(input logic b, output logic s);
      sda_m = b;
      wq();
      if (glitch_en) begin
         scl_m = 1'b1; @(negedge clk); @(negedge clk); scl_m = 1'b0;
      end
      scl_m = 1'b1;
      wq();
      s = sda_bus;
      if (glitch_en && b) begin
         sda_m = 1'b0; @(negedge clk); @(negedge clk); sda_m = 1'b1;
      end
      wq();
      scl_m = 1'b0;
      wq();
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
      bit_xfer(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] v, output logic ninth);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, s);
         v[i] = s;
      end
      bit_xfer(!mack, ninth);
   endtask

   task automatic check_outs(input string req);
      repeat (20) @(negedge clk);
      chk(req, 32'({baseband, sap_level, alc_en, mute, force_mono, audio_mode}), 32'(exp_main[6:0]));
      chk(req, 32'(test_sel), 32'(exp_code(exp_test)));
   endtask

   task automatic do_write(input logic [6:0] a, input int n, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2, input string req);
      logic ack;
      logic [7:0] bs [3];
      bs[0] = b0; bs[1] = b1; bs[2] = b2;
      bus_start();
      send_byte({a, 1'b0}, ack);
      chk((a == ADDR) ? "R2 address ack" : "R2 mismatch no ack", 32'(ack), 32'(a == ADDR));
      for (int k = 0; k < n; k++) begin
         send_byte(bs[k], ack);
         chk((k >= 2) ? "R9 surplus byte ack" : "R2 data ack", 32'(ack), 32'(a == ADDR));
      end
      bus_stop();
      if (a == ADDR && n >= 1) begin
         exp_main = b0;
         if (n >= 2) exp_test = b1;
         else        exp_test = 8'h00;
      end
      check_outs(req);
   endtask

   task automatic do_read(input int n, input logic flip);
      logic ack, ninth;
      logic [7:0] v, expv;
      bus_start();
      send_byte({ADDR, 1'b1}, ack);
      chk("R2 read address ack", 32'(ack), 32'd1);
      expv = {stereo, sap, 6'b0};
      if (flip) begin
         stereo = ~stereo;
         sap    = ~sap;
      end
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, v, ninth);
         chk("R7 status byte", 32'(v), 32'(expv));
         if (k == n - 1) chk("R8 ninth clock released on NACK", 32'(ninth), 32'd1);
      end
      repeat (20) @(negedge clk);
      chk("R8 SDA released after NACK", 32'(sda_pull), 32'd0);
      bus_stop();
   endtask

   initial begin
      logic ack, s;
      void'($urandom(32'h5EED_2024));
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 reset controls", 32'({baseband, sap_level, alc_en, mute, force_mono, audio_mode, test_sel}), 32'd0);
      chk("R1 reset SDA released", 32'(sda_pull), 32'd0);

      // directed field and monitor-code cases
      do_write(ADDR, 2, 8'h55, 8'h05, 8'h00, "R3 R4 main and monitor");
      do_write(ADDR, 2, 8'hFF, 8'h0D, 8'h00, "R3 bit 7 ignored, R4 code 13");
      do_write(ADDR, 2, 8'h2A, 8'h0E, 8'h00, "R4 code 14 no effect");
      do_write(ADDR, 2, 8'h13, 8'hF3, 8'h00, "R4 large code no effect");
      do_write(ADDR, 2, 8'h13, 8'h07, 8'h00, "R4 code 7");
      do_write(ADDR, 1, 8'h4C, 8'h00, 8'h00, "R5 STOP after main clears monitor");
      do_write(ADDR, 2, 8'h01, 8'h09, 8'h00, "R4 code 9");
      do_write(ADDR, 3, 8'h62, 8'h03, 8'hFF, "R9 surplus byte ignored");
      do_write(ADDR ^ 7'h01, 2, 8'h7F, 8'h02, 8'h00, "R2 mismatch leaves registers");

      // partial byte ended by STOP
      bus_start();
      send_byte({ADDR, 1'b0}, ack);
      for (int i = 0; i < 5; i++) bit_xfer(1'b0, s);
      bus_stop();
      check_outs("R6 partial byte at STOP");

      // partial byte ended by repeated START, then a full write
      bus_start();
      send_byte({ADDR, 1'b0}, ack);
      for (int i = 0; i < 3; i++) bit_xfer(1'b1, s);
      bus_start();
      chk("R6 repeated START no change", 32'(test_sel), 32'(exp_code(exp_test)));
      send_byte({ADDR, 1'b0}, ack);
      send_byte(8'h35, ack);
      send_byte(8'h0B, ack);
      bus_stop();
      exp_main = 8'h35; exp_test = 8'h0B;
      check_outs("R6 write after repeated START");

      // reads
      stereo = 1'b1; sap = 1'b0;
      do_read(1, 1'b1);
      stereo = 1'b0; sap = 1'b1;
      do_read(2, 1'b1);
      stereo = 1'b1; sap = 1'b1;
      do_read(1, 1'b0);
      check_outs("R7 read leaves controls");

      // glitch robustness
      glitch_en = 1'b1;
      do_write(ADDR, 2, 8'h5A, 8'h06, 8'h00, "R10 spikes on SCL and SDA ignored");
      glitch_en = 1'b0;

      // constrained random mix
      for (int it = 0; it < 16; it++) begin
         int kind;
         logic [6:0] a;
         kind = int'($urandom % 4);
         a = ADDR;
         if ($urandom % 5 == 0) a = ADDR ^ 7'($urandom_range(1, 127));
         if (kind == 3) begin
            stereo = 1'($urandom); sap = 1'($urandom);
            do_read(1 + int'($urandom % 2), 1'($urandom));
         end else begin
            do_write(a, kind + 1, 8'($urandom), 8'($urandom % 20), 8'($urandom),
                     "R3 R4 R5 R9 random write");
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule